// File: doc/BRIEF.md
# Attenuation Ramp Generator

The block produces the gain for one input of an audio mixer. When it is switched on, it loads a programmed starting gain. On paced frame ticks it then moves that gain geometrically toward a programmed target. A downward ramp multiplies the gain by a fraction. An upward ramp closes a fraction of the distance that is left to full scale. Once the target is reached or crossed, the gain is clamped to the target and held there. One instance is placed per mixer input, and its `mix_gain` output drives that input's multiplier.

All gains and factors are unsigned 18-bit fractions with 18 fractional bits. Full scale is 0x3FFFF. The register bank in front of the block supplies the control word, the starting value, the two factors and the target as plain ports. After power-on that bank is expected to hold 0x3FFFF for the starting value, 0x2AAAA for the up factor, 0x30000 for the down factor and 0x00010 for the target. The live gain and the number of applied steps are brought out for read-back.

Top module: `atten_ramp`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cur_gain` and `step_count` are 0 and `mix_gain` is 0x3FFFF.
- R2: While `ctrl[0]` (enable) is 0, `mix_gain` is 0x3FFFF. `cur_gain` and `step_count` keep their values, whatever `frame_tick` does.
- R3: At a clock edge where `ctrl[0]` is 1 and was 0 at the previous edge, `cur_gain` takes `init_val` and `step_count` becomes 0. A `frame_tick` at that edge is not counted.
- R4: While enabled and not holding, a step is applied on each (D+1)-th frame tick after the load or after the last step, where D is `ctrl[13:2]`. D = 0 steps on every tick, and no step happens without a tick.
- R5: With `ctrl[1]` = 0 (downward), a step computes floor(gain × `dn_factor` / 2^18).
- R6: With `ctrl[1]` = 1 (upward), a step computes gain + floor((0x3FFFF − gain) × `up_factor` / 2^18).
- R7: When a downward step result is at or below `target`, or an upward step result is at or above `target`, `cur_gain` becomes `target`. No further steps are applied until the next enable rise.
- R8: `step_count` increments by one on every applied step, including the step that clamps.
- R9: While enabled, `mix_gain` equals `cur_gain`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-cycle pulse per audio frame |
| ctrl | input | 14 | bit 0 enable, bit 1 direction (1 = up), bits 13:2 step divider |
| init_val | input | 18 | Gain loaded on enable rise |
| up_factor | input | 18 | Fraction of the remaining headroom added per upward step |
| dn_factor | input | 18 | Multiplier per downward step |
| target | input | 18 | Gain at which the ramp stops |
| mix_gain | output | 18 | Gain sent to the mixer multiplier |
| cur_gain | output | 18 | Live ramp value for read-back |
| step_count | output | 18 | Steps applied since the last enable rise |

## Verification
The bench runs a downward ramp to a small target and an upward ramp toward a high target. It also runs a divider larger than one with sparse ticks, and turns enable on again with a tick in the same cycle. A random phase flips the direction, the divider and the target in the middle of a ramp. A design that misses the clamp would settle just past the target or keep stepping. An off-by-one divider would step one tick early or late, and the cycle-by-cycle compare catches that at once. A design that lets the load tick count as a step would start the count at 1. A design that drops the headroom term in the upward formula would produce wrong gains from the first upward step.

// File: rtl/atten_ramp.sv
module atten_ramp #(
  parameter int W     = 18,
  parameter int DIV_W = 12,
  localparam int CTRL_W = DIV_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [W-1:0]      init_val,
  input  logic [W-1:0]      up_factor,
  input  logic [W-1:0]      dn_factor,
  input  logic [W-1:0]      target,
  output logic [W-1:0]      mix_gain,
  output logic [W-1:0]      cur_gain,
  output logic [W-1:0]      step_count
);
  localparam logic [W-1:0] FULL = '1;

  logic             en_q, held_q;
  logic [DIV_W-1:0] div_q;
  logic [W-1:0]     gain_q, cnt_q;
  logic [W-1:0]     dn_hi, dn_lo, up_hi, up_lo, next_gain;
  logic [W:0]       up_sum;
  logic             en, up, load, active, div_hit, reach;

  assign en      = ctrl[0];
  assign up      = ctrl[1];
  assign load    = en && !en_q;
  assign active  = en && en_q && !held_q;
  assign div_hit = (div_q == ctrl[CTRL_W-1:2]);

  assign {dn_hi, dn_lo} = {{W{1'b0}}, gain_q} * {{W{1'b0}}, dn_factor};
  assign {up_hi, up_lo} = {{W{1'b0}}, FULL - gain_q} * {{W{1'b0}}, up_factor};
  assign up_sum = {1'b0, gain_q} + {1'b0, up_hi};

  assign reach     = up ? (up_sum >= {1'b0, target}) : (dn_hi <= target);
  assign next_gain = reach ? target : (up ? up_sum[W-1:0] : dn_hi);

  wire unused_lo = ^{dn_lo, up_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      held_q <= 1'b0;
      div_q  <= '0;
      gain_q <= '0;
      cnt_q  <= '0;
    end else begin
      en_q <= en;
      if (load) begin
        gain_q <= init_val;
        cnt_q  <= '0;
        div_q  <= '0;
        held_q <= 1'b0;
      end else if (active && frame_tick) begin
        if (div_hit) begin
          gain_q <= next_gain;
          cnt_q  <= cnt_q + 1'b1;
          div_q  <= '0;
          held_q <= reach;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign mix_gain   = en ? gain_q : FULL;
  assign cur_gain   = gain_q;
  assign step_count = cnt_q;

  AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !en_q) |=> (cur_gain == $past(init_val)) && (step_count == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |=> $stable(cur_gain) && $stable(step_count)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_count != $past(step_count)) |-> (step_count == W'($past(step_count) + 1'b1)) || (step_count == '0)); // R8
  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (step_count != $past(step_count) && step_count != '0) |-> $past(frame_tick)); // R4
  AST_HOLD_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_q) |-> (cur_gain == $past(target))); // R7
endmodule

// File: tb/atten_ramp_tb.sv
module atten_ramp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic [13:0] ctrl = '0;
  logic [17:0] init_val = 18'h3FFFF, up_factor = 18'h2AAAA, dn_factor = 18'h30000, target = 18'h00010;
  logic [17:0] mix_gain, cur_gain, step_count;

  int total = 0, bad = 0;
  bit done = 0;
  string ph = "R1";

  longint m_gain = 0, m_cnt = 0, m_div = 0;
  bit m_held = 0, m_enq = 0;
  localparam longint FS = 64'h3FFFF;

  always #10 clk = ~clk;

  atten_ramp u_dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .ctrl(ctrl),
    .init_val(init_val), .up_factor(up_factor), .dn_factor(dn_factor), .target(target),
    .mix_gain(mix_gain), .cur_gain(cur_gain), .step_count(step_count)
  );

  // behavioural reference, evaluated from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_gain = 0; m_cnt = 0; m_div = 0; m_held = 0; m_enq = 0;
    end else begin
      if (ctrl[0] && !m_enq) begin
        m_gain = init_val; m_cnt = 0; m_div = 0; m_held = 0;
      end else if (ctrl[0] && !m_held && frame_tick) begin
        if (m_div == longint'(ctrl[13:2])) begin
          longint nx;
          if (ctrl[1]) begin
            nx = m_gain + (((FS - m_gain) * longint'(up_factor)) >>> 18);
            if (nx >= longint'(target)) begin nx = target; m_held = 1; end
          end else begin
            nx = (m_gain * longint'(dn_factor)) >>> 18;
            if (nx <= longint'(target)) begin nx = target; m_held = 1; end
          end
          m_gain = nx;
          m_cnt = (m_cnt + 1) % 262144;
          m_div = 0;
        end else begin
          m_div = m_div + 1;
        end
      end
      m_enq = ctrl[0];
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    check(ph, "cur_gain", cur_gain, m_gain);
    check(ph, "step_count", step_count, m_cnt);
    check(ctrl[0] ? "R9" : "R2", "mix_gain", mix_gain, ctrl[0] ? m_gain : FS);
  endtask

  task automatic cyc(bit tk);
    frame_tick = tk;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: values during reset
    check("R1", "cur_gain in reset", cur_gain, 0);
    check("R1", "step_count in reset", step_count, 0);
    check("R1", "mix_gain in reset", mix_gain, FS);
    rst_n = 1'b1;
    cyc(0);

    // R2: disabled, ticks have no effect
    ph = "R2";
    for (int i = 0; i < 10; i++) cyc(1);
    check("R2", "idle mix_gain", mix_gain, FS);
    check("R2", "idle step_count", step_count, 0);

    // R5 / R7: downward ramp to a small target, one step per tick
    ph = "R5";
    init_val = 18'h3FFFF; dn_factor = 18'h30000; target = 18'h00010;
    ctrl = {12'd0, 1'b0, 1'b1};
    cyc(1);
    check("R3", "load value", cur_gain, 18'h3FFFF);
    check("R3", "load clears count, tick ignored", step_count, 0);
    for (int i = 0; i < 60; i++) cyc(1);
    check("R7", "clamped to target", cur_gain, 18'h00010);
    check("R8", "down step count", step_count, m_cnt);
    cyc(1);
    check("R7", "held after clamp", cur_gain, 18'h00010);

    // R2: disable keeps state, R4: divider 3 with sparse ticks
    ph = "R2";
    ctrl = '0;
    for (int i = 0; i < 5; i++) cyc(1);
    check("R2", "state kept while off", cur_gain, 18'h00010);
    ph = "R4";
    init_val = 18'h20000; dn_factor = 18'h38000; target = 18'h00100;
    ctrl = {12'd3, 1'b0, 1'b1};
    cyc(0);
    for (int i = 0; i < 7; i++) begin cyc(1); cyc(0); end
    check("R4", "one step after four ticks", step_count, 1);
    check("R4", "first paced step", cur_gain, 18'h1C000);
    for (int i = 0; i < 60; i++) begin cyc(1); cyc(0); end

    // R6: upward ramp with divider 1
    ph = "R6";
    ctrl = '0; cyc(0);
    init_val = 18'h00100; up_factor = 18'h2AAAA; target = 18'h3FF00;
    ctrl = {12'd1, 1'b1, 1'b1};
    cyc(0);
    for (int i = 0; i < 80; i++) cyc(1);
    check("R7", "up ramp clamped", cur_gain, 18'h3FF00);

    // R3: re-enable with a tick at the rising edge
    ph = "R3";
    ctrl = '0; cyc(1);
    init_val = 18'h12345; ctrl = {12'd0, 1'b1, 1'b1};
    cyc(1);
    check("R3", "reload value", cur_gain, 18'h12345);
    check("R3", "reload count", step_count, 0);
    cyc(1);
    check("R8", "first step counted", step_count, 1);

    // R8: random direction, divider and target changes
    ph = "R8";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 40) == 0) begin
        ctrl = {12'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 5) != 0)};
        init_val = 18'($urandom); target = 18'($urandom);
        up_factor = 18'($urandom); dn_factor = 18'($urandom);
      end
      cyc(1'($urandom_range(0, 1)));
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule